// File: doc/BRIEF.md
# Parallel Carry-Chain Resolution Unit

This unit finishes a multi-word addition that was first done lane by lane, with no carries passed between lanes. Each lane of the earlier additions leaves a carry-state element with two small fields. The count field holds how many carries the lane produced. The limit field holds how many further incoming carries the lane can take before it overflows again. From the whole carry-state vector and a scalar chained carry-in, the unit builds a correction vector. Adding that vector lane by lane to the partial sums gives the exact wide result. The carry that leaves the top lane becomes a scalar chained carry-out.

Every lane compares the carry arriving from below with its own limit, and these compares all happen at once. The per-lane result is placed one element higher, so the chained carry-in fills element 0 and the top lane's result leaves as the carry-out. Because carry-in and carry-out may live in one shared scalar register, the carry-in is sampled when an input is accepted. The carry-out that replaces it appears with the result.

The input and output are valid/ready streams. An input is accepted on a clock edge where `s_valid` and `s_ready` are both high. Its result appears on the next edge with `m_valid` high. The result is held unchanged until it is taken on an edge where `m_ready` is high. While a result waits with `m_ready` low, `s_ready` is low and no new input is accepted. When the result is taken on the same edge, a new input may be accepted on that edge.

Top module: `carry_resolve`

## Requirements
- R1: After reset, `m_valid` is low and `s_ready` is high.
- R2: Element 0 of `m_corr` (bits `[LANE_W-1:0]`) equals the `s_cin` value accepted with the input.
- R3: Lane i holds count `s_cnt[i*CW +: CW]` and limit `s_lim[i*CW +: CW]`. Its arriving carry A_i is `s_cin` for lane 0 and the value of element i of the correction for lanes above 0. Element i+1 of `m_corr` equals the count plus one when A_i is strictly greater than the limit, and equals the count alone otherwise.
- R4: `m_cout` equals the lane result of the top lane, LANES-1, under the rule of R3.
- R5: When the arriving carry equals the limit exactly, no extra one is added. When the arriving carry exceeds the limit by one, an extra one is added, including when that arriving carry was itself raised by an overflow one lane lower.
- R6: Bits `[LANE_W-1:CW]` of every lane of `m_corr` are zero.
- R7: An input accepted at one clock edge makes `m_valid` high with its result after that same edge, a latency of one cycle.
- R8: While `m_valid` is high and `m_ready` is low, `m_corr` and `m_cout` hold their values, `m_valid` stays high and `s_ready` is low.
- R9: Take a chain of 1 to 14 lane-wise additions with limits saturated at 2^CW-1, and any carry-in up to 2^CW-1. Adding `m_corr` lane by lane, modulo 2^LANE_W per lane, to the partial sums and placing `m_cout` above the top lane gives the exact wide sum of all operands plus the carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input carry-state vector is valid |
| s_ready | output | 1 | Unit can accept an input this cycle |
| s_cnt | input | LANES*CW | Per-lane carry counts, lane 0 in the low bits |
| s_lim | input | LANES*CW | Per-lane carry-in limits, lane 0 in the low bits |
| s_cin | input | CW | Scalar chained carry-in |
| m_valid | output | 1 | Correction result is valid |
| m_ready | input | 1 | Consumer takes the result this cycle |
| m_corr | output | LANES*LANE_W | Correction vector, zero-extended lanes |
| m_cout | output | CW | Scalar chained carry-out |

## Verification
The assertions assume that the consumer follows the stream rules. They also assume that no count exceeds 14 and that a limit is the free headroom of its lane, saturated at 2^CW-1. Under those assumptions no result can wrap its field. The stimulus builds every carry-state vector either by hand within those bounds or from a modelled chain of at most 14 lane-wise additions. In those chains each limit is derived from the partial sum and clipped to the field's maximum.

// File: rtl/crr_pkg.sv
package crr_pkg;
  // Longest chain of lane-wise additions before a resolution pass is required.
  parameter int unsigned CRR_MAX_ADDS = 14;

  // Smallest field width able to hold a count plus one extra carry.
  function automatic int unsigned crr_min_cw(input int unsigned max_adds);
    int unsigned w;
    w = 1;
    while ((1 << w) <= max_adds + 1) w++;
    return w;
  endfunction
endpackage

// File: rtl/crr_lane.sv
module crr_lane #(
  parameter int unsigned CW = 4
) (
  input  logic [CW-1:0] arrive,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] lim,
  output logic [CW-1:0] res
);
  logic over;

  always_comb begin
    over = (arrive > lim);
    res  = cnt + {{(CW-1){1'b0}}, over};
  end
endmodule

// File: rtl/crr_chain.sv
module crr_chain #(
  parameter int unsigned LANES = 4,
  parameter int unsigned CW    = 4
) (
  input  logic [LANES*CW-1:0]     cnt,
  input  logic [LANES*CW-1:0]     lim,
  input  logic [CW-1:0]           cin,
  output logic [(LANES+1)*CW-1:0] elems
);
  // elems holds LANES+1 values: cin at index 0, lane i result at index i+1.
  assign elems[CW-1:0] = cin;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    crr_lane #(.CW(CW)) u_lane (
      .arrive (elems[i*CW +: CW]),
      .cnt    (cnt[i*CW +: CW]),
      .lim    (lim[i*CW +: CW]),
      .res    (elems[(i+1)*CW +: CW])
    );
  end
endmodule

// File: rtl/crr_outreg.sv
module crr_outreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/carry_resolve.sv
module carry_resolve
  import crr_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned CW     = crr_min_cw(CRR_MAX_ADDS),
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [LANES*CW-1:0]     s_cnt,
  input  logic [LANES*CW-1:0]     s_lim,
  input  logic [CW-1:0]           s_cin,
  output logic                    m_valid,
  input  logic                    m_ready,
  output logic [LANES*LANE_W-1:0] m_corr,
  output logic [CW-1:0]           m_cout
);
  localparam int unsigned PAD   = LANE_W - CW;
  localparam int unsigned OUT_W = LANES * LANE_W + CW;

  logic [(LANES+1)*CW-1:0] elems;
  logic [LANES*LANE_W-1:0] corr_c;
  logic [OUT_W-1:0]        out_q;

  crr_chain #(.LANES(LANES), .CW(CW)) u_chain (
    .cnt   (s_cnt),
    .lim   (s_lim),
    .cin   (s_cin),
    .elems (elems)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_ext
    if (PAD > 0) begin : g_pad
      assign corr_c[i*LANE_W +: LANE_W] = {{PAD{1'b0}}, elems[i*CW +: CW]};
    end else begin : g_nopad
      assign corr_c[i*LANE_W +: LANE_W] = elems[i*CW +: LANE_W];
    end
  end

  crr_outreg #(.W(OUT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s_valid),
    .in_ready  (s_ready),
    .in_data   ({elems[LANES*CW +: CW], corr_c}),
    .out_valid (m_valid),
    .out_ready (m_ready),
    .out_data  (out_q)
  );

  assign m_corr = out_q[LANES*LANE_W-1:0];
  assign m_cout = out_q[OUT_W-1 -: CW];
endmodule

// File: rtl/carry_resolve_chk.sv
module carry_resolve_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned CW     = 4,
  parameter int unsigned LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    s_valid,
  input logic                    s_ready,
  input logic [CW-1:0]           s_cin,
  input logic                    m_valid,
  input logic                    m_ready,
  input logic [LANES*LANE_W-1:0] m_corr,
  input logic [CW-1:0]           m_cout
);
  // R7
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> m_valid);

  // R2
  cin_lands_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> m_corr[LANE_W-1:0] == LANE_W'($past(s_cin)));

  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_corr) && $stable(m_cout));

  // R8
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |-> !s_ready);

  // R6
  for (genvar i = 0; i < LANES; i++) begin : g_pad
    if (LANE_W > CW) begin : g_on
      upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> m_corr[i*LANE_W+CW +: (LANE_W-CW)] == '0);
    end
  end
endmodule

bind carry_resolve carry_resolve_chk #(.LANES(LANES), .CW(CW), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_cin(s_cin),
  .m_valid(m_valid), .m_ready(m_ready), .m_corr(m_corr), .m_cout(m_cout)
);

// File: tb/carry_resolve_tb.sv
module carry_resolve_tb;
  localparam int unsigned LANES  = 4;
  localparam int unsigned CW     = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned LMAX = (1 << CW) - 1;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    s_valid = 1'b0;
  logic                    s_ready;
  logic [LANES*CW-1:0]     s_cnt = '0;
  logic [LANES*CW-1:0]     s_lim = '0;
  logic [CW-1:0]           s_cin = '0;
  logic                    m_valid;
  logic                    m_ready = 1'b1;
  logic [LANES*LANE_W-1:0] m_corr;
  logic [CW-1:0]           m_cout;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  carry_resolve #(.LANES(LANES), .CW(CW), .LANE_W(LANE_W)) u_dut (.*);

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Reference model written from R2..R4 and R6.
  task automatic model(input logic [LANES*CW-1:0] cnt, input logic [LANES*CW-1:0] lim,
                       input logic [CW-1:0] cin,
                       output logic [LANES*LANE_W-1:0] corr, output logic [CW-1:0] cout);
    int unsigned e [LANES+1];
    e[0] = cin;
    for (int i = 0; i < LANES; i++)
      e[i+1] = cnt[i*CW +: CW] + ((e[i] > lim[i*CW +: CW]) ? 1 : 0);
    corr = '0;
    for (int i = 0; i < LANES; i++) corr[i*LANE_W +: LANE_W] = LANE_W'(e[i]);
    cout = CW'(e[LANES]);
  endtask

  // Drive one input with the consumer ready, and check the result one cycle later.
  task automatic send_check(input string req, input logic [LANES*CW-1:0] cnt,
                            input logic [LANES*CW-1:0] lim, input logic [CW-1:0] cin);
    logic [LANES*LANE_W-1:0] ec;
    logic [CW-1:0] eo;
    model(cnt, lim, cin, ec, eo);
    @(negedge clk);
    s_cnt = cnt; s_lim = lim; s_cin = cin; s_valid = 1'b1; m_ready = 1'b1;
    @(posedge clk); #1;
    check({req, " R7 valid"}, 64'(m_valid), 64'd1);
    check({req, " corr"}, 64'(m_corr), 64'(ec));
    check({req, " cout"}, 64'(m_cout), 64'(eo));
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 m_valid", 64'(m_valid), 64'd0);
    check("R1 s_ready", 64'(s_ready), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_cin_only;
    // R2: only the carry-in, all lanes empty, limits saturated
    send_check("R2 cin=5", '0, {LANES{CW'(LMAX)}}, CW'(5));
    send_check("R2 cin=15", '0, {LANES{CW'(LMAX)}}, CW'(15));
    check("R6 upper zero", 64'(m_corr & ~{LANES{LANE_W'(LMAX)}}), 64'd0);
  endtask

  task automatic t_equal_limit;
    // R5: lane0 count 3, lane1 limit 3 -> no extra; limit 2 -> extra one
    logic [LANES*CW-1:0] cnt, lim;
    cnt = '0; cnt[0 +: CW] = 3;
    lim = {LANES{CW'(LMAX)}}; lim[CW +: CW] = 3;
    send_check("R5 equal", cnt, lim, '0);
    check("R5 equal elem2", 64'(m_corr[2*LANE_W +: LANE_W]), 64'd0);
    lim[CW +: CW] = 2;
    send_check("R5 exceed", cnt, lim, '0);
    check("R5 exceed elem2", 64'(m_corr[2*LANE_W +: LANE_W]), 64'd1);
  endtask

  task automatic t_ripple;
    // R3/R4: every lane full (limit 0), carry-in 1 walks to the top
    send_check("R3 ripple", '0, '0, CW'(1));
    check("R3 ripple corr", 64'(m_corr), 64'h01010101);
    check("R4 ripple cout", 64'(m_cout), 64'd1);
  endtask

  task automatic t_max_counts;
    // R4: counts of 14 with no overflow pass straight through
    send_check("R4 max", {LANES{CW'(14)}}, {LANES{CW'(LMAX)}}, '0);
    check("R4 max cout", 64'(m_cout), 64'd14);
  endtask

  task automatic t_backpressure;
    logic [LANES*LANE_W-1:0] ea, eb;
    logic [CW-1:0] oa, ob;
    logic [LANES*CW-1:0] cb;
    cb = {LANES{CW'(2)}};
    model('0, {LANES{CW'(LMAX)}}, CW'(7), ea, oa);
    model(cb, {LANES{CW'(LMAX)}}, CW'(3), eb, ob);
    @(negedge clk);
    m_ready = 1'b0;
    s_cnt = '0; s_lim = {LANES{CW'(LMAX)}}; s_cin = CW'(7); s_valid = 1'b1;
    @(posedge clk); #1;
    check("R7 first valid", 64'(m_valid), 64'd1);
    @(negedge clk);
    s_cnt = cb; s_cin = CW'(3);
    check("R8 s_ready low", 64'(s_ready), 64'd0);
    repeat (3) @(posedge clk);
    #1;
    check("R8 held corr", 64'(m_corr), 64'(ea));
    check("R8 held cout", 64'(m_cout), 64'(oa));
    check("R8 still valid", 64'(m_valid), 64'd1);
    @(negedge clk);
    m_ready = 1'b1;
    @(posedge clk); #1;
    check("R8 next corr", 64'(m_corr), 64'(eb));
    check("R8 next cout", 64'(m_cout), 64'(ob));
    @(negedge clk);
    s_valid = 1'b0;
    @(posedge clk); #1;
    check("R8 drained", 64'(m_valid), 64'd0);
  endtask

  task automatic t_random_chains(input int runs);
    for (int r = 0; r < runs; r++) begin
      int unsigned v [LANES];
      int unsigned c [LANES];
      logic [63:0] ref_sum, recon;
      logic [LANES*CW-1:0] cnt, lim;
      logic [CW-1:0] cin;
      int n;
      n = 1 + ($urandom % 14);
      ref_sum = '0;
      for (int i = 0; i < LANES; i++) begin v[i] = 0; c[i] = 0; end
      for (int k = 0; k < n; k++) begin
        logic [31:0] op;
        op = $urandom;
        if (r % 3 == 0) op = op | 32'hFFFF_FF00;
        ref_sum = ref_sum + 64'(op);
        for (int i = 0; i < LANES; i++) begin
          int unsigned t;
          t = v[i] + op[i*LANE_W +: LANE_W];
          v[i] = t % (1 << LANE_W);
          c[i] = c[i] + t / (1 << LANE_W);
        end
      end
      cin = CW'($urandom % (LMAX + 1));
      ref_sum = ref_sum + 64'(cin);
      for (int i = 0; i < LANES; i++) begin
        int unsigned head;
        head = (1 << LANE_W) - 1 - v[i];
        cnt[i*CW +: CW] = CW'(c[i]);
        lim[i*CW +: CW] = CW'((head > LMAX) ? LMAX : head);
      end
      send_check("R9 chain", cnt, lim, cin);
      recon = 64'(m_cout) << (LANES * LANE_W);
      for (int i = 0; i < LANES; i++)
        recon = recon | (64'((v[i] + m_corr[i*LANE_W +: LANE_W]) % (1 << LANE_W)) << (i * LANE_W));
      check("R9 wide sum", recon, ref_sum);
    end
  endtask

  initial begin
    t_reset();
    t_cin_only();
    t_equal_limit();
    t_ripple();
    t_max_counts();
    t_backpressure();
    t_random_chains(200);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule